// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on a bus address path and decides, for each access, whether the address falls inside one programmable memory window. Software sets the window with two registers. The base register holds a 24-bit base below a fixed 0x1F prefix. The control register holds a 5-bit size exponent N, which gives a window of 2^N bytes, anywhere from one byte to 2 GB.

The base is always aligned to the window size: the low N bits of the programmed base take no part in matching. An access that hits produces a registered hit and the byte offset inside the window. An access that lands inside the prefix aperture at or above the aligned base but past the end of the window raises a one-cycle error pulse. The same access also sets a sticky error flag. Software clears the flag by writing 1 to its bit.

Top module: `awd_window_dec`

## Requirements
- R1: With `reg_sel`=0, `reg_rdata` returns the last written base in bits 23:0 as written (unaligned) and the constant 0x1F in bits 31:24; a write with `reg_sel`=0 stores `reg_wdata[23:0]` only.
- R2: With `reg_sel`=1, `reg_rdata` returns the size exponent N in bits 20:16 and the error flag in bit 28, and every other bit reads as zero; a write with `reg_sel`=1 stores N from `reg_wdata[20:16]`.
- R3: The effective base is {0x1F, base} with its low N bits cleared; a valid access hits when its address with the low N bits cleared equals the effective base; `hit` shows the result one clock after the access is presented.
- R4: `offset` equals the low N bits of the accessed address (higher bits zero) in the cycle `hit` is 1, and is zero whenever `hit` is 0.
- R5: A valid access whose address has bits 31:24 equal to 0x1F, is greater than or equal to the effective base, and does not hit, gives `err_pulse`=1 for exactly one cycle, one clock after the access; `err_pulse` and `hit` are never both 1.
- R6: Every error pulse sets `err_flag` on the same edge, and the flag stays set without further errors.
- R7: A write with `reg_sel`=1 and `reg_wdata[28]`=1 clears the flag; a write with bit 28 at 0 leaves it unchanged.
- R8: When an error and a clearing write fall in the same cycle, the flag ends up set.
- R9: An access presented in the same cycle as a register write is decoded with the register values from before that write.
- R10: After synchronous reset, base, N, flag, `hit`, `offset` and `err_pulse` are zero, so the base register reads 0x1F000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_sel` |
| acc_valid | input | 1 | Bus access present |
| acc_addr | input | 32 | Bus access address |
| hit | output | 1 | Registered window hit |
| offset | output | 32 | Registered offset inside the window |
| err_pulse | output | 1 | One-cycle out-of-window error |
| err_flag | output | 1 | Sticky error flag |

## Verification
For every N from 0 to 31, the bench uses an unaligned random base. It probes the aligned base, the last byte of the window, the first byte past it, and the byte just below the base. These probes separate a correct mask from one that is off by one bit, and a hit from an error. Random addresses inside and outside the 0x1F prefix check that accesses outside the aperture neither hit nor raise an error. Directed steps cover the clear-by-write semantics, a clear that collides with a new error, and a register write together with an access in the same cycle, which shows whether the old or the new configuration is used.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned AW       = 32;
  localparam int unsigned BW       = 24;
  localparam int unsigned SW       = 5;
  localparam int unsigned PW       = AW - BW;
  localparam logic [PW-1:0] PREFIX = 8'h1F;
  localparam int unsigned SIZE_LSB = 16;
  localparam int unsigned ERR_BIT  = 28;

  typedef struct packed {
    logic [BW-1:0] base;
    logic [SW-1:0] size;
  } win_cfg_t;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          err_set,
  output win_cfg_t      cfg,
  output logic          err_flag,
  output logic [AW-1:0] reg_rdata
);
  logic          clr_req;
  logic [AW-1:0] rd_mux;

  assign clr_req = reg_wr && reg_sel && reg_wdata[ERR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      err_flag <= 1'b0;
    end else begin
      if (reg_wr && !reg_sel) cfg.base <= reg_wdata[BW-1:0];
      if (reg_wr && reg_sel)  cfg.size <= reg_wdata[SIZE_LSB +: SW];
      if (err_set)            err_flag <= 1'b1;
      else if (clr_req)       err_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (!reg_sel) begin
      rd_mux = {PREFIX, cfg.base};
    end else begin
      rd_mux[SIZE_LSB +: SW] = cfg.size;
      rd_mux[ERR_BIT]        = err_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R7: a clearing write without a concurrent error drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !err_set) |=> !err_flag);
  // R7: without error or clear the flag holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!err_set && !clr_req) |=> $stable(err_flag));
  // R8: an error always leaves the flag set, clear or not
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    err_set |=> err_flag);
endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  win_cfg_t      cfg,
  output logic          err_now,
  output logic          hit_q,
  output logic [AW-1:0] off_q,
  output logic          err_q
);
  logic [AW-1:0] win_mask;
  logic [AW-1:0] eff_base;
  logic          in_win;
  logic          in_aperture;

  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign win_mask[i] = (i < int'(cfg.size));
  end

  assign eff_base    = {PREFIX, cfg.base} & ~win_mask;
  assign in_win      = (acc_addr & ~win_mask) == eff_base;
  assign in_aperture = (acc_addr[AW-1:BW] == PREFIX) && (acc_addr >= eff_base);
  assign err_now     = acc_valid && in_aperture && !in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      off_q <= '0;
      err_q <= 1'b0;
    end else begin
      hit_q <= acc_valid && in_win;
      off_q <= (acc_valid && in_win) ? (acc_addr & win_mask) : '0;
      err_q <= err_now;
    end
  end

  // R5: hit and error are exclusive
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hit_q && err_q));
  // R4: no offset leaks out on a miss
  a_r4_off_zero: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> (off_q == '0));
  // R3: a result only follows a presented access
  a_r3_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (hit_q || err_q) |-> $past(acc_valid));
endmodule

// File: rtl/awd_window_dec.sv
module awd_window_dec
  import awd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          acc_valid,
  input  logic [31:0]   acc_addr,
  output logic          hit,
  output logic [31:0]   offset,
  output logic          err_pulse,
  output logic          err_flag
);
  win_cfg_t cfg;
  logic     err_now;

  awd_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .err_set   (err_now),
    .cfg       (cfg),
    .err_flag  (err_flag),
    .reg_rdata (reg_rdata)
  );

  awd_match u_match (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .cfg       (cfg),
    .err_now   (err_now),
    .hit_q     (hit),
    .off_q     (offset),
    .err_q     (err_pulse)
  );

  // R6: the sticky flag is up whenever a pulse is out
  a_r6_flag_follows: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_flag);
endmodule

// File: tb/sim_awd_window_dec.sv
module sim_awd_window_dec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        hit;
  logic [31:0] offset;
  logic        err_pulse;
  logic        err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] m_base = '0;
  logic [4:0]  m_size = '0;
  logic        m_flag = 1'b0;

  always #10 clk = ~clk;

  awd_window_dec u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .hit(hit), .offset(offset),
    .err_pulse(err_pulse), .err_flag(err_flag)
  );

  function automatic logic [31:0] f_mask(logic [4:0] n);
    logic [32:0] one;
    one = 33'h1 << n;
    return 32'(one - 33'h1);
  endfunction

  function automatic logic [31:0] f_ebase(logic [23:0] b, logic [4:0] n);
    return {8'h1F, b} & ~f_mask(n);
  endfunction

  function automatic logic f_hit(logic [31:0] a, logic [23:0] b, logic [4:0] n);
    return (a & ~f_mask(n)) == f_ebase(b, n);
  endfunction

  function automatic logic f_err(logic [31:0] a, logic [23:0] b, logic [4:0] n);
    return (a[31:24] == 8'h1F) && (a >= f_ebase(b, n)) && !f_hit(a, b, n);
  endfunction

  function automatic logic [31:0] f_read(logic s);
    logic [31:0] r;
    r = '0;
    if (!s) r = {8'h1F, m_base};
    else begin r[20:16] = m_size; r[28] = m_flag; end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: optional access and optional write, all outputs checked
  task automatic step(bit va, logic [31:0] a, bit w, bit s, logic [31:0] d, string tag);
    logic        e_hit, e_err, e_flag;
    logic [31:0] e_off, e_rd;
    @(negedge clk);
    acc_valid = va; acc_addr = a; reg_wr = w; reg_sel = s; reg_wdata = d;
    e_hit  = va && f_hit(a, m_base, m_size);
    e_err  = va && f_err(a, m_base, m_size);
    e_off  = e_hit ? (a & f_mask(m_size)) : '0;
    e_rd   = f_read(s);
    e_flag = e_err ? 1'b1 : ((w && s && d[28]) ? 1'b0 : m_flag);
    if (w && !s) m_base = d[23:0];
    if (w && s)  m_size = d[20:16];
    m_flag = e_flag;
    @(negedge clk);
    acc_valid = 1'b0; reg_wr = 1'b0;
    chk({tag, " R3 hit"}, 32'(hit), 32'(e_hit));
    chk({tag, " R4 offset"}, offset, e_off);
    chk({tag, " R5 err_pulse"}, 32'(err_pulse), 32'(e_err));
    chk({tag, " R6/R7 err_flag"}, 32'(err_flag), 32'(e_flag));
    chk({tag, " R1/R2 rdata"}, reg_rdata, e_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] eb, sz;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state, both registers
    step(0, '0, 0, 0, '0, "R10 base");
    step(0, '0, 0, 1, '0, "R10 ctrl");
    // R1: only low 24 bits stored, prefix constant
    step(0, '0, 1, 0, 32'hABCDE123, "R1 wr");
    step(0, '0, 0, 0, '0, "R1 rd");
    // R2: unused control bits read zero
    step(0, '0, 1, 1, 32'hEFFF_FFFF & ~32'h1000_0000, "R2 wr");
    step(0, '0, 0, 1, '0, "R2 rd");
    for (int n = 0; n < 32; n++) begin
      step(0, '0, 1, 0, $urandom, "R1 base");
      step(0, '0, 1, 1, ($urandom & 32'hEFE0_FFFF) | (32'(n) << 16), "R2 size");
      eb = f_ebase(m_base, m_size);
      sz = 32'(f_mask(m_size)) + 32'd1;
      step(1, eb, 0, 1, '0, "R3 base");
      step(1, eb + sz - 32'd1, 0, 0, '0, "R3 last");
      step(1, eb + sz, 0, 1, '0, "R5 past end");
      step(1, eb - 32'd1, 0, 0, '0, "R5 below");
      step(1, {8'h1F, 24'($urandom)}, 0, 1, '0, "R3 rand in prefix");
      step(1, $urandom, 0, 0, '0, "R5 rand any");
      step(0, $urandom, 0, 1, '0, "R3 idle");
      // R7 write 0 to flag bit keeps it, write 1 clears
      step(0, '0, 1, 1, (32'(n) << 16), "R7 keep");
      step(0, '0, 1, 1, (32'(n) << 16) | 32'h1000_0000, "R7 clear");
    end
    // R8: error and clear together
    step(0, '0, 1, 0, 32'h0010_0000, "R8 base");
    step(0, '0, 1, 1, 32'h0004_0000, "R8 size");
    step(1, 32'h1F20_0000, 1, 1, 32'h1004_0000, "R8 collide");
    step(0, '0, 0, 1, '0, "R8 rd");
    step(0, '0, 1, 1, 32'h1004_0000, "R7 clear2");
    // R9: access with a size write in the same cycle uses the old size
    step(1, 32'h1F10_0010, 1, 1, 32'h0000_0000, "R9 same cycle");
    step(1, 32'h1F10_0010, 0, 1, '0, "R9 after");
    // R9: base write with access
    step(1, 32'h1F30_0000, 1, 0, 32'h0030_0000, "R9 base same");
    step(1, 32'h1F30_0000, 0, 0, '0, "R9 base after");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule